// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block divides each nominal CAN bit into time quanta and four segments that always run in this order: one synchronisation quantum, a propagation segment, phase 1 and phase 2. A programmable prescaler sets the quantum length in system clocks. The propagation segment gives the bus delay time to settle. The receive line is sampled where phase 1 ends. The block outputs the sampled bit, a one-clock sample strobe, and a one-clock transmit-point strobe that marks the start of the next bit.

The bus input first passes through a two-stage synchroniser. It is then looked at once per quantum. Only a falling edge, which is a change from recessive (1) to dominant (0), can move the bit timing. While the bus is idle, the frame logic raises the hard-sync enable. The first falling edge then restarts the bit, and the quantum that holds the edge counts as the synchronisation segment. At other times an edge causes a resynchronisation. A late edge, seen in the propagation segment or in phase 1, lengthens phase 1. An early edge, seen in phase 2, shortens phase 2. Each adjustment is limited by the jump width, and only one is made between two sample points.

Top module: `can_bit_timer`

## Requirements
- R1: A quantum lasts `prescale` system clocks. A value of 0 is treated as 1.
- R2: Field values `prop_len`, `ph1_len` and `ph2_len` of n give n+1 quanta. With no edges, a bit lasts 1+(prop_len+1)+(ph1_len+1)+(ph2_len+1) quanta, and `sample_stb` fires once per bit.
- R3: `rx_bit` takes the synchronised bus value when phase 1 ends. It changes only in the cycle where `sample_stb` is high.
- R4: `tx_stb` is a one-clock pulse when a bit ends, either at the end of phase 2 or at a restart caused by an early edge. It is never high together with `sample_stb`. At prescale 1 it arrives phase-2-length clocks after the sample strobe.
- R5: A falling edge in the propagation segment or in phase 1 lengthens phase 1 by its lateness. The lateness is the number of quanta from the end of the synchronisation segment, counting the quantum of the edge. The extension is at most sjw+1 quanta.
- R6: A falling edge in phase 2 shortens the bit by its earliness. The earliness is the number of phase-2 quanta left, counting the quantum of the edge. If the earliness is at most sjw+1, the quantum of the edge becomes the synchronisation segment of the next bit. If it is larger, phase 2 loses exactly sjw+1 quanta.
- R7: A rising edge has no effect on timing, and neither does a falling edge inside the synchronisation segment.
- R8: Only one resynchronisation is made between two sample points. A second falling edge in the same interval is ignored.
- R9: While `hard_sync_en` is high, a falling edge in any segment restarts the bit. The quantum of the edge counts as the synchronisation segment.
- R10: During reset and after it, `sample_stb` and `tx_stb` are 0 and `rx_bit` is 1 until the first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prescale | input | PSC_W | System clocks per quantum (0 acts as 1) |
| prop_len | input | SEG_W | Propagation segment length minus one, in quanta |
| ph1_len | input | SEG_W | Phase 1 length minus one, in quanta |
| ph2_len | input | SEG_W | Phase 2 length minus one, in quanta |
| sjw | input | SJW_W | Jump width minus one, in quanta |
| hard_sync_en | input | 1 | Bus idle: the next falling edge hard-synchronises |
| rx | input | 1 | Asynchronous bus receive line, 1 = recessive |
| rx_bit | output | 1 | Bus value taken at the last sample point |
| sample_stb | output | 1 | One-clock pulse at each sample point |
| tx_stb | output | 1 | One-clock pulse at each bit start (transmit point) |

## Verification
The hardest case to reach is an edge that lands in one chosen quantum, because the synchroniser and the once-per-quantum edge check delay the input. Each edge test first waits for a sample strobe, which fixes the phase of the bit. It then drives the line a calculated number of clocks later and measures the clocks up to the next one or two sample strobes. The cases covered are a late edge inside the jump width, a late edge beyond it, an early edge that restarts the bit, an early edge limited by the jump width, a rising edge, an edge in the synchronisation segment, a double edge and a hard synchronisation. Each gives its own expected interval.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_quantum_gen.sv
module cbt_quantum_gen #(
  parameter int PSC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] prescale,
  output logic             tq_tick
);
  logic [PSC_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  // a count at or beyond the limit wraps, so shrinking the prescaler is safe
  assign wrap    = (prescale <= PSC_W'(1)) || (cnt_q >= prescale - PSC_W'(1));
  assign cnt_d   = wrap ? '0 : cnt_q + PSC_W'(1);
  assign tq_tick = wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cbt_rx_edge.sv
module cbt_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_tick,
  input  logic rx,
  output logic rx_sync,
  output logic rx_fall
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= rx;
      sync_q <= meta_q;
    end
  end

  // quantum-rate history, updated on the clock enable only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_q <= 1'b1;
    else if (tq_tick) last_q <= sync_q;
  end

  assign rx_sync = sync_q;
  assign rx_fall = last_q & ~sync_q;
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
  import cbt_pkg::*;
#(
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             rx_sync,
  input  logic             rx_fall,
  input  logic             hard_sync_en,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw,
  output logic             rx_bit,
  output logic             sample_stb,
  output logic             tx_stb
);
  localparam int CNT_W = ((SEG_W > SJW_W) ? SEG_W : SJW_W) + 2;

  seg_e             seg_q, seg_d;
  logic [CNT_W-1:0] qcnt_q, qcnt_d, ph1_lim_q, ph1_lim_d, ph2_lim_q, ph2_lim_d;
  logic             used_q, used_d, bit_q, bit_d, samp_q, samp_d, txp_q, txp_d;

  logic [CNT_W-1:0] prop_qn, ph1_qn, ph2_qn, jump_qn, late, early, ph1_use, ph2_use;
  logic             resync_ok, restart;

  assign prop_qn = CNT_W'(prop_len) + CNT_W'(1);
  assign ph1_qn  = CNT_W'(ph1_len) + CNT_W'(1);
  assign ph2_qn  = CNT_W'(ph2_len) + CNT_W'(1);
  assign jump_qn = CNT_W'(sjw) + CNT_W'(1);
  assign late    = (seg_q == SEG_PH1) ? prop_qn + qcnt_q + CNT_W'(1) : qcnt_q + CNT_W'(1);
  assign early   = ph2_lim_q - qcnt_q;
  assign resync_ok = tq_tick && rx_fall && !used_q && !hard_sync_en;

  always_comb begin
    seg_d     = seg_q;
    qcnt_d    = qcnt_q;
    ph1_lim_d = ph1_lim_q;
    ph2_lim_d = ph2_lim_q;
    used_d    = used_q;
    bit_d     = bit_q;
    samp_d    = 1'b0;
    txp_d     = 1'b0;
    ph1_use   = ph1_lim_q;
    ph2_use   = ph2_lim_q;
    restart   = 1'b0;

    if (resync_ok && (seg_q == SEG_PROP || seg_q == SEG_PH1)) begin
      ph1_use = ph1_lim_q + ((late < jump_qn) ? late : jump_qn);
      used_d  = 1'b1;
    end
    if (resync_ok && seg_q == SEG_PH2) begin
      used_d = 1'b1;
      if (early <= jump_qn) restart = 1'b1;
      else                  ph2_use = ph2_lim_q - jump_qn;
    end

    if (tq_tick) begin
      ph1_lim_d = ph1_use;
      ph2_lim_d = ph2_use;
      if (rx_fall && hard_sync_en) begin
        seg_d     = SEG_PROP;
        qcnt_d    = '0;
        ph1_lim_d = ph1_qn;
        ph2_lim_d = ph2_qn;
        used_d    = 1'b1;
      end else if (restart) begin
        seg_d     = SEG_PROP;
        qcnt_d    = '0;
        ph1_lim_d = ph1_qn;
        ph2_lim_d = ph2_qn;
        txp_d     = 1'b1;
      end else begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_d     = SEG_PROP;
            qcnt_d    = '0;
            ph1_lim_d = ph1_qn;
            ph2_lim_d = ph2_qn;
          end
          SEG_PROP: begin
            if (qcnt_q >= prop_qn - CNT_W'(1)) begin
              seg_d  = SEG_PH1;
              qcnt_d = '0;
            end else qcnt_d = qcnt_q + CNT_W'(1);
          end
          SEG_PH1: begin
            if (qcnt_q >= ph1_use - CNT_W'(1)) begin
              seg_d  = SEG_PH2;
              qcnt_d = '0;
              samp_d = 1'b1;
              bit_d  = rx_sync;
              used_d = 1'b0;
            end else qcnt_d = qcnt_q + CNT_W'(1);
          end
          SEG_PH2: begin
            if (qcnt_q >= ph2_use - CNT_W'(1)) begin
              seg_d  = SEG_SYNC;
              qcnt_d = '0;
              txp_d  = 1'b1;
            end else qcnt_d = qcnt_q + CNT_W'(1);
          end
          default: seg_d = SEG_SYNC;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q     <= SEG_SYNC;
      qcnt_q    <= '0;
      ph1_lim_q <= CNT_W'(1);
      ph2_lim_q <= CNT_W'(1);
      used_q    <= 1'b0;
      bit_q     <= 1'b1;
      samp_q    <= 1'b0;
      txp_q     <= 1'b0;
    end else begin
      seg_q     <= seg_d;
      qcnt_q    <= qcnt_d;
      ph1_lim_q <= ph1_lim_d;
      ph2_lim_q <= ph2_lim_d;
      used_q    <= used_d;
      bit_q     <= bit_d;
      samp_q    <= samp_d;
      txp_q     <= txp_d;
    end
  end

  assign rx_bit     = bit_q;
  assign sample_stb = samp_q;
  assign tx_stb     = txp_q;
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PSC_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] prescale,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw,
  input  logic             hard_sync_en,
  input  logic             rx,
  output logic             rx_bit,
  output logic             sample_stb,
  output logic             tx_stb
);
  logic [1:0] rst_pipe;
  logic       rst_int_n, tq_tick, rx_sync, rx_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  cbt_quantum_gen #(.PSC_W(PSC_W)) u_tq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .prescale (prescale),
    .tq_tick  (tq_tick)
  );

  cbt_rx_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tq_tick (tq_tick),
    .rx      (rx),
    .rx_sync (rx_sync),
    .rx_fall (rx_fall)
  );

  cbt_seg_fsm #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .tq_tick      (tq_tick),
    .rx_sync      (rx_sync),
    .rx_fall      (rx_fall),
    .hard_sync_en (hard_sync_en),
    .prop_len     (prop_len),
    .ph1_len      (ph1_len),
    .ph2_len      (ph2_len),
    .sjw          (sjw),
    .rx_bit       (rx_bit),
    .sample_stb   (sample_stb),
    .tx_stb       (tx_stb)
  );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int PSC_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input logic clk,
  input logic rst_n,
  input logic hard_sync_en,
  input logic rx_bit,
  input logic sample_stb,
  input logic tx_stb
);
  localparam int MAX_Q   = 1 + 3 * (1 << SEG_W) + (1 << SJW_W);
  localparam int GAP_MAX = MAX_Q * ((1 << PSC_W) - 1) + 4;
  localparam int GAP_W   = $clog2(GAP_MAX + 2) + 1;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         gap_q <= '0;
    else if (sample_stb || hard_sync_en) gap_q <= '0;
    else if (gap_q <= GAP_W'(GAP_MAX))  gap_q <= gap_q + GAP_W'(1);
  end

  p_stb_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb));

  p_tx_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |=> !tx_stb);

  p_samp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  p_rxbit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_bit) |-> sample_stb);

  p_gap_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GAP_W'(GAP_MAX));
endmodule

bind can_bit_timer can_bit_timer_chk #(.PSC_W(PSC_W), .SEG_W(SEG_W), .SJW_W(SJW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hard_sync_en (hard_sync_en),
  .rx_bit       (rx_bit),
  .sample_stb   (sample_stb),
  .tx_stb       (tx_stb)
);

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] prescale = 6'd1;
  logic [2:0] prop_len = 3'd1, ph1_len = 3'd2, ph2_len = 3'd2;
  logic [1:0] sjw = 2'd1;
  logic       hard_sync_en = 1'b0;
  logic       rx = 1'b1;
  logic       rx_bit, sample_stb, tx_stb;
  int         total = 0;
  int         bad = 0;

  always #5 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .prop_len(prop_len),
    .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw(sjw), .hard_sync_en(hard_sync_en),
    .rx(rx), .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_stb(tx_stb)
  );

  // psc, prop, ph1, ph2, expected clocks between sample strobes
  localparam int NROW = 6;
  localparam int TBL [NROW][5] = '{
    '{1, 0, 0, 0, 4},
    '{1, 7, 7, 7, 25},
    '{3, 1, 2, 2, 27},
    '{2, 0, 3, 1, 16},
    '{5, 2, 0, 0, 30},
    '{0, 1, 1, 1, 7}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_samp();
    do @(negedge clk); while (!sample_stb);
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) wait_samp();
  endtask

  // Align on a sample strobe, then drive rx at given negedge counts (0 = unused)
  task automatic probe(input int k_fall, input int k_rise, input int k_fall2,
                       output int t1, output int t2);
    t1 = 0; t2 = 0;
    wait_samp();
    for (int i = 1; i <= 80; i++) begin
      @(negedge clk);
      if (sample_stb) begin
        if (t1 == 0) t1 = i;
        else if (t2 == 0) t2 = i;
      end
      if (i == k_fall)  rx = 1'b0;
      if (i == k_rise)  rx = 1'b1;
      if (i == k_fall2) rx = 1'b0;
      if (t2 != 0) break;
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t1, t2, gap;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 sample_stb in reset", int'(sample_stb), 0);
    check("R10 tx_stb in reset", int'(tx_stb), 0);
    check("R10 rx_bit in reset", int'(rx_bit), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rx_bit after reset", int'(rx_bit), 1);

    // R1/R2: bit length table, rx held recessive
    for (int r = 0; r < NROW; r++) begin
      prescale = 6'(TBL[r][0]);
      prop_len = 3'(TBL[r][1]);
      ph1_len  = 3'(TBL[r][2]);
      ph2_len  = 3'(TBL[r][3]);
      settle(3);
      gap = 0;
      do begin @(negedge clk); gap++; end while (!sample_stb);
      check($sformatf("R1 R2 row %0d clocks per bit", r), gap, TBL[r][4]);
      check("R3 rx_bit recessive", int'(rx_bit), 1);
    end

    // edge tests: prop 2, ph1 3, ph2 3 quanta, jump 2, prescale 1 -> 9 clocks
    prescale = 6'd1; prop_len = 3'd1; ph1_len = 3'd2; ph2_len = 3'd2; sjw = 2'd1;
    settle(3);

    // R4: transmit point three clocks after the sample point
    wait_samp();
    gap = 0;
    do begin @(negedge clk); gap++; end while (!tx_stb);
    check("R4 tx_stb delay after sample", gap, 3);

    // R5: edge in first propagation quantum, lateness 1
    probe(2, 0, 0, t1, t2);
    check("R5 late edge interval", t1, 10);
    check("R3 sampled dominant", int'(rx_bit), 0);
    settle(2);

    // R7: rising edge in propagation segment does nothing
    probe(0, 2, 0, t1, t2);
    check("R7 rising edge interval", t1, 9);
    check("R3 sampled recessive", int'(rx_bit), 1);
    settle(2);

    // R5: lateness 4 capped at jump 2
    probe(5, 0, 0, t1, t2);
    check("R5 late edge capped", t1, 11);
    rx = 1'b1;
    settle(2);

    // R6: early edge with earliness 2 restarts the bit
    probe(8, 0, 0, t1, t2);
    check("R6 early restart first interval", t1, 9);
    check("R6 early restart interval", t2 - t1, 7);
    rx = 1'b1;
    settle(2);

    // R6: earliness 3 with jump 1 shortens phase 2 by 1
    sjw = 2'd0;
    settle(1);
    probe(7, 0, 0, t1, t2);
    check("R6 early limited interval", t2 - t1, 8);
    rx = 1'b1;
    sjw = 2'd1;
    settle(2);

    // R8: second falling edge in the same interval is ignored
    probe(2, 3, 4, t1, t2);
    check("R8 double edge interval", t1, 10);
    rx = 1'b1;
    settle(2);

    // R7: falling edge inside synchronisation segment
    probe(1, 0, 0, t1, t2);
    check("R7 edge in sync segment", t1, 9);
    rx = 1'b1;
    settle(2);

    // R9: hard synchronisation on edge in phase 1
    hard_sync_en = 1'b1;
    probe(4, 0, 0, t1, t2);
    check("R9 hard sync interval", t1, 12);
    hard_sync_en = 1'b0;
    rx = 1'b1;
    settle(2);
    probe(0, 0, 0, t1, t2);
    check("R2 nominal after hard sync", t1, 9);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule